// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Target

This block is a two-wire bus target that behaves like a byte-addressed serial EEPROM. It runs entirely in the system clock domain: the bus clock and data lines are sampled through synchronizers, and start and stop conditions are found from the synchronized levels. The bus data line is driven only through an open-drain enable, so a high on `sda_oe` pulls the wire low.

A host selects the target with a device word. A write transfer carries two word-address bytes and then data bytes. The data bytes collect in a page buffer and reach the array only when a stop arrives. A self-timed write cycle then runs for a parameterized number of system clocks. During that cycle the target is silent, so a host can poll it until it acknowledges again. Reads start at an internal pointer. They use either that pointer as it stands, or an address loaded by a write transfer that carries no data followed by a repeated start. Reads continue for as long as the host acknowledges.

The array depth (`ADDR_W`), the page size (`PAGE_W`) and the write-cycle length (`WR_CYCLES`) are parameters. The bus itself has no back-pressure beyond what the protocol provides: the target never stretches the clock, and a host sees the busy phase only as a missing acknowledge.

Top module: `i2c_eeprom_target`

## Requirements
- R1: A falling data line while the clock line is high is a start condition, and a rising data line while the clock is high is a stop condition. A start seen at any point of a transfer abandons that transfer and begins reception of a new device word (repeated start). The target changes `sda_oe` only while the synchronized clock line is low.
- R2: The device word is sent MSB first. Bits 7:4 must equal 1010, bits 3:1 must equal `chip_sel`, and bit 0 selects read (1) or write (0). On a match the target pulls the data line low for the ninth clock. On a mismatch it gives no acknowledge and ignores the bus until the next start.
- R3: After a write device word, the target receives a high and then a low word-address byte and acknowledges each. The pointer is loaded with the low `ADDR_W` bits of the 16-bit value, and the upper bits have no effect.
- R4: Each data byte of a write is acknowledged and placed at the pointer. Only the low `PAGE_W` pointer bits then advance, wrapping inside the page, so bytes beyond one page overwrite earlier bytes of the same page.
- R5: The array changes only when a write transfer ends with a stop. If a write transfer ends with a repeated start, its buffered bytes are discarded. A write that carries only the address changes nothing and starts no write cycle.
- R6: After a stop that ends a write with data, the target is busy for max(`WR_CYCLES`, 2^`PAGE_W`) system clocks. While busy it ignores all traffic and does not acknowledge its device word. Afterwards it acknowledges again.
- R7: While `wp` is high, the address and data bytes are still acknowledged. No byte reaches the array, and no write cycle starts after the stop, so the device word is acknowledged right away.
- R8: The pointer keeps the last accessed address plus one (page-wrapped after writes) across transfers. A read that has no address phase returns the byte at the pointer.
- R9: A read returns consecutive bytes while the host acknowledges each one. The address wraps from the last array byte to 0. A host non-acknowledge ends the read.
- R10: After reset the data line is released and the target is idle and not busy, so it acknowledges its device word at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Open-drain enable; 1 pulls the data line low |
| chip_sel | input | 3 | Strap value compared with device word bits 3:1 |
| wp | input | 1 | Write protect; 1 blocks all array writes |

## Verification
The bench builds the target with `ADDR_W`=8, `PAGE_W`=4 and `WR_CYCLES`=300. The 256-byte array can therefore be filled page by page and read back in one sequential pass that crosses the wrap to address 0. A 16-byte page makes the in-page overwrite reachable with a 20-byte write. The write-cycle length is longer than one device-word exchange, so the first poll after a write must see no acknowledge, and a later poll must see one. All 128 combinations of the device-type nibble and chip-select bits are swept against a fixed strap value.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RD,
    ST_WAIT
  } ee_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int PW = SYNC_STAGES + 1;

  logic [1:0] raw;
  logic [1:0] cur;
  logic [1:0] prv;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [PW-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[PW-2:0], raw[g]};
    end
    assign cur[g] = pipe[PW-2];
    assign prv[g] = pipe[PW-1];
  end

  assign scl_s     = cur[0];
  assign sda_s     = cur[1];
  assign scl_rise  = cur[0] & ~prv[0];
  assign scl_fall  = ~cur[0] & prv[0];
  assign start_det = cur[0] & prv[0] & prv[1] & ~cur[1];
  assign stop_det  = cur[0] & prv[0] & ~prv[1] & cur[1];

endmodule

// File: rtl/i2c_ee_pagebuf.sv
module i2c_ee_pagebuf #(
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [PAGE_W-1:0] rd_idx,
  output logic [7:0]        rd_data,
  output logic              rd_valid
);
  localparam int PAGE = 1 << PAGE_W;

  logic [7:0]      data_q [PAGE];
  logic [PAGE-1:0] vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (clr) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) data_q[wr_idx] <= wr_data;
  end

  assign rd_data  = data_q[rd_idx];
  assign rd_valid = vld_q[rd_idx];

endmodule

// File: rtl/i2c_ee_wtimer.sv
module i2c_ee_wtimer
  import i2c_ee_pkg::*;
#(
  parameter int WR_CYCLES = 1000,
  parameter int PAGE_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick,
  output logic              busy,
  output logic              commit_en,
  output logic [PAGE_W-1:0] commit_idx
);
  localparam int PAGE = 1 << PAGE_W;
  localparam int LEN  = imax(WR_CYCLES, PAGE);
  localparam int CW   = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] elapsed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    else if (kick)         cnt_q <= CW'(LEN);
  end

  assign busy       = (cnt_q != '0);
  assign elapsed    = CW'(LEN) - cnt_q;
  assign commit_en  = busy && (elapsed < CW'(PAGE));
  assign commit_idx = elapsed[PAGE_W-1:0];

endmodule

// File: rtl/i2c_ee_mem.sv
module i2c_ee_mem #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) arr[waddr] <= wdata;
  end

  assign rdata = arr[raddr];

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import i2c_ee_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = 6,
  parameter int WR_CYCLES   = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] chip_sel,
  input  logic       wp
);
  localparam int HI_W = ADDR_W - PAGE_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy, commit_en, kick;
  logic [PAGE_W-1:0] commit_idx;
  logic [7:0] pb_rdata, mem_rdata;
  logic pb_rvalid, mem_we, pb_wr, pb_clr;

  ee_state_e         state;
  logic [3:0]        bitcnt;
  logic              in_ack;
  logic              rnw;
  logic              hack;
  logic              pend;
  logic [7:0]        shreg;
  logic [7:0]        tx_sh;
  logic [7:0]        addr_hi;
  logic [ADDR_W-1:0] ptr;
  logic [15:0]       word_addr;
  logic              byte_done, ack_end, dev_match, bus_free, rx_state;

  i2c_ee_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_ee_wtimer #(.WR_CYCLES(WR_CYCLES), .PAGE_W(PAGE_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .kick(kick), .busy(busy),
    .commit_en(commit_en), .commit_idx(commit_idx)
  );

  i2c_ee_pagebuf #(.PAGE_W(PAGE_W)) u_pbuf (
    .clk(clk), .rst_n(rst_n), .clr(pb_clr), .wr_en(pb_wr),
    .wr_idx(ptr[PAGE_W-1:0]), .wr_data(shreg),
    .rd_idx(commit_idx), .rd_data(pb_rdata), .rd_valid(pb_rvalid)
  );

  i2c_ee_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr({ptr[ADDR_W-1:PAGE_W], commit_idx}),
    .wdata(pb_rdata), .raddr(ptr), .rdata(mem_rdata)
  );

  assign bus_free  = !busy && !start_det && !stop_det;
  assign byte_done = scl_fall && (bitcnt == 4'd8) && !in_ack;
  assign ack_end   = scl_fall && in_ack;
  assign dev_match = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == chip_sel);
  assign word_addr = {addr_hi, shreg};
  assign rx_state  = (state == ST_DEV) || (state == ST_AHI) ||
                     (state == ST_ALO) || (state == ST_WDAT);

  assign pb_wr  = bus_free && (state == ST_WDAT) && byte_done && !wp;
  assign pb_clr = !busy && start_det;
  assign kick   = !busy && stop_det && pend && !wp;
  assign mem_we = commit_en && pb_rvalid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pend <= 1'b0;
    else if (!busy && (start_det || stop_det)) pend <= 1'b0;
    else if (pb_wr)                  pend <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      in_ack  <= 1'b0;
      rnw     <= 1'b0;
      hack    <= 1'b0;
      shreg   <= '0;
      tx_sh   <= '0;
      addr_hi <= '0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
    end else if (busy) begin
      state  <= ST_IDLE;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      state  <= ST_DEV;
      bitcnt <= '0;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
    end else if (rx_state) begin
      if (scl_rise && !in_ack && (bitcnt != 4'd8)) begin
        shreg  <= {shreg[6:0], sda_s};
        bitcnt <= bitcnt + 1'b1;
      end else if (byte_done) begin
        unique case (state)
          ST_DEV: begin
            if (dev_match) begin
              sda_oe <= 1'b1;
              in_ack <= 1'b1;
              rnw    <= shreg[0];
            end else begin
              state <= ST_WAIT;
            end
          end
          ST_AHI: begin
            addr_hi <= shreg;
            sda_oe  <= 1'b1;
            in_ack  <= 1'b1;
          end
          ST_ALO: begin
            ptr    <= word_addr[ADDR_W-1:0];
            sda_oe <= 1'b1;
            in_ack <= 1'b1;
          end
          default: begin
            ptr    <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
            sda_oe <= 1'b1;
            in_ack <= 1'b1;
          end
        endcase
      end else if (ack_end) begin
        in_ack <= 1'b0;
        bitcnt <= '0;
        sda_oe <= 1'b0;
        unique case (state)
          ST_DEV: begin
            if (rnw) begin
              state  <= ST_RD;
              tx_sh  <= mem_rdata;
              sda_oe <= ~mem_rdata[7];
              ptr    <= ptr + 1'b1;
            end else begin
              state <= ST_AHI;
            end
          end
          ST_AHI:  state <= ST_ALO;
          default: state <= ST_WDAT;
        endcase
      end
    end else if (state == ST_RD) begin
      if (scl_rise && (bitcnt == 4'd8)) begin
        hack <= ~sda_s;
      end else if (scl_fall) begin
        if (bitcnt < 4'd7) begin
          tx_sh  <= {tx_sh[6:0], 1'b0};
          sda_oe <= ~tx_sh[6];
          bitcnt <= bitcnt + 1'b1;
        end else if (bitcnt == 4'd7) begin
          sda_oe <= 1'b0;
          bitcnt <= 4'd8;
        end else if (hack) begin
          tx_sh  <= mem_rdata;
          sda_oe <= ~mem_rdata[7];
          ptr    <= ptr + 1'b1;
          bitcnt <= '0;
        end else begin
          state <= ST_WAIT;
        end
      end
    end
  end

  if (HI_W < 1 || ADDR_W > 16) begin : g_bad_cfg
    initial $display("i2c_eeprom_target: ADDR_W must exceed PAGE_W and be at most 16");
  end

endmodule

// File: rtl/i2c_ee_chk.sv
module i2c_ee_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_oe,
  input logic busy,
  input logic stop_det,
  input logic mem_we,
  input logic wp
);

  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s); // R1

  AST_OE_FALL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_s); // R1

  AST_SILENT_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe); // R6

  AST_CYCLE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det)); // R5

  AST_WRITE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R6

  AST_PROTECT_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wp)); // R7

endmodule

bind i2c_eeprom_target i2c_ee_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .busy(busy), .stop_det(stop_det), .mem_we(mem_we), .wp(wp)
);

// File: tb/test_i2c_eeprom_target.sv
module test_i2c_eeprom_target;
  localparam int AW  = 8;
  localparam int PW  = 4;
  localparam int WRC = 300;
  localparam int HP  = 5;
  localparam int Q   = 2;
  localparam int NB  = 1 << AW;
  localparam logic [2:0] CS = 3'b101;
  localparam logic [7:0] DW = {4'b1010, CS, 1'b0};
  localparam logic [7:0] DR = {4'b1010, CS, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic host_sda = 1'b1;
  logic wp = 1'b0;
  logic sda_oe;
  logic sda_bus;
  int   n_chk = 0;
  int   n_err = 0;
  int   cyc = 0;
  logic [7:0] model [NB];

  always #2.5 clk = ~clk;
  assign sda_bus = host_sda & ~sda_oe;

  i2c_eeprom_target #(.ADDR_W(AW), .PAGE_W(PW), .WR_CYCLES(WRC)) i_i2c_eeprom_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .chip_sel(CS), .wp(wp)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    host_sda = 1'b1; tick(HP);
    scl = 1'b1;      tick(HP);
    host_sda = 1'b0; tick(HP);
    scl = 1'b0;      tick(Q);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; tick(HP);
    scl = 1'b1;      tick(HP);
    host_sda = 1'b1; tick(HP);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      host_sda = b[i]; tick(HP);
      scl = 1'b1;      tick(HP);
      scl = 1'b0;      tick(Q);
    end
    host_sda = 1'b1; tick(HP);
    scl = 1'b1;      tick(HP);
    ack = ~sda_bus;
    scl = 1'b0;      tick(Q);
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] d);
    host_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(HP);
      scl = 1'b1; tick(HP);
      d[i] = sda_bus;
      scl = 1'b0; tick(Q);
    end
    host_sda = ~give_ack; tick(HP);
    scl = 1'b1;           tick(HP);
    scl = 1'b0;           tick(Q);
    host_sda = 1'b1;
  endtask

  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo);
    logic a;
    bus_start();
    send_byte(DW, a); check("R3 device word ack", a, 1);
    send_byte(hi, a); check("R3 high address ack", a, 1);
    send_byte(lo, a); check("R3 low address ack", a, 1);
  endtask

  task automatic poll(output logic a);
    bus_start();
    send_byte(DW, a);
    bus_stop();
  endtask

  task automatic wait_ready(string req);
    logic a;
    int   tries;
    poll(a);
    check({req, " first poll not acked"}, a, 0);
    tries = 0;
    while (!a && tries < 20) begin
      poll(a);
      tries++;
    end
    check({req, " acked after cycle"}, a, 1);
  endtask

  task automatic rd_chk(string req, input logic [7:0] hi, input logic [7:0] lo, input int n);
    logic a;
    logic [7:0] d;
    set_addr(hi, lo);
    bus_start();
    send_byte(DR, a); check({req, " read word ack"}, a, 1);
    for (int i = 0; i < n; i++) begin
      read_byte(i != n - 1, d);
      check(req, d, model[(int'(lo) + i) % NB]);
    end
    bus_stop();
  endtask

  task automatic cur_chk(string req, input int exp_addr);
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(DR, a); check({req, " read word ack"}, a, 1);
    read_byte(1'b0, d);
    check(req, d, model[exp_addr]);
    bus_stop();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_err++;
      $display("FAIL watchdog: actual %0d expected below 190000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    tick(10);
    check("R10 data line released in reset", sda_oe, 0);
    rst_n = 1'b1;
    tick(5);
    check("R10 data line released after reset", sda_oe, 0);

    // R2: sweep device-type nibble and chip-select bits, write direction
    for (int hi = 0; hi < 16; hi++) begin
      for (int c = 0; c < 8; c++) begin
        bus_start();
        send_byte({hi[3:0], c[2:0], 1'b0}, a);
        check("R2 device word decode", a, (hi == 10 && c == int'(CS)) ? 1 : 0);
        bus_stop();
      end
    end

    // R4 / R6: fill the whole array page by page
    for (int p = 0; p < NB / (1 << PW); p++) begin
      set_addr(8'h00, 8'(p << PW));
      for (int k = 0; k < (1 << PW); k++) begin
        int ad;
        ad = (p << PW) + k;
        send_byte(8'((ad * 37 + 11) & 255), a);
        check("R4 data byte ack", a, 1);
        model[ad] = 8'((ad * 37 + 11) & 255);
      end
      bus_stop();
      wait_ready("R6 write cycle");
    end

    // R9: sequential read across the wrap to address 0
    rd_chk("R9 sequential read with wrap", 8'h00, 8'h00, NB + 2);
    // R8: pointer continues after that read at (NB+2) mod NB
    cur_chk("R8 current address after read", 2);

    // R4: 20-byte write into a 16-byte page starting at offset 5
    set_addr(8'h00, 8'h35);
    for (int k = 0; k < 20; k++) begin
      send_byte(8'((k * 13 + 161) & 255), a);
      check("R4 page data ack", a, 1);
      model[8'h30 | ((5 + k) & 15)] = 8'((k * 13 + 161) & 255);
    end
    bus_stop();
    wait_ready("R6 page write cycle");
    cur_chk("R8 pointer after page write", 8'h39);
    rd_chk("R4 page wrap contents", 8'h00, 8'h30, 16);

    // R5: address-only write starts no cycle
    set_addr(8'h00, 8'h80);
    bus_stop();
    poll(a);
    check("R5 no cycle after address-only write", a, 1);
    cur_chk("R8 pointer after address-only write", 8'h80);

    // R1 / R3 / R5: write aborted by repeated start
    set_addr(8'hFF, 8'h22);
    send_byte(8'h5A, a); check("R4 data ack before abort", a, 1);
    bus_start();
    send_byte(DR, a); check("R1 repeated start read word ack", a, 1);
    read_byte(1'b0, d);
    check("R1 read after repeated start", d, model[8'h23]);
    bus_stop();
    poll(a);
    check("R5 no cycle after aborted write", a, 1);
    rd_chk("R5 aborted byte not written", 8'h00, 8'h22, 1);
    rd_chk("R3 upper address bits ignored", 8'hC3, 8'h10, 2);

    // R7: write protect
    wp = 1'b1;
    set_addr(8'h00, 8'h40);
    for (int k = 0; k < 3; k++) begin
      send_byte(8'hEE, a);
      check("R7 protected data ack", a, 1);
    end
    bus_stop();
    poll(a);
    check("R7 no cycle under protect", a, 1);
    wp = 1'b0;
    rd_chk("R7 array unchanged under protect", 8'h00, 8'h40, 3);

    // R8: single byte write then current address read
    set_addr(8'h00, 8'h7F);
    send_byte(8'h3C, a); check("R4 byte write ack", a, 1);
    model[8'h7F] = 8'h3C;
    bus_stop();
    wait_ready("R6 byte write cycle");
    cur_chk("R8 pointer wraps in page after write", 8'h70);
    rd_chk("R4 byte write stored", 8'h00, 8'h7F, 1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule